// File: doc/BRIEF.md
# Interrupt Priority Indirect Access Window

This block gives a hart's CSR unit indirect access to per-level interrupt priority storage. It has three select registers, one each for machine, supervisor and virtual-supervisor level, and three matching data CSRs. A select register holds an index. A read-modify-write on the matching data CSR then reaches whatever that index names. Select values 0x30..0x3F name packed groups of byte-wide priorities in a 64-entry array kept for the machine level and another kept for the supervisor level. Select values 0x70..0xFF name interrupt-file registers. Those registers live outside the block and are reached through a forwarding port that answers in the same cycle.

Every access is combinational in the cycle `csr_en` is high: read data and the fault flags are valid in that cycle, and the stored state changes at the next rising clock edge. With virtualization on, supervisor-level accesses are steered to the virtual-supervisor registers. A failed access reports one of two fault kinds. The CSR pipeline uses the fault kind to pick the exception it raises.

Top module: `irq_prio_window`

## Requirements
- R1: Every access returns the old value on `csr_rdata`. The stored value becomes (old & ~mask) | (new & mask). A zero mask leaves the state unchanged.
- R2: Select registers keep only the bits set in the legal mask (default 0xFFF, 12 bits). They read back zero-extended, and an access to a select CSR never faults.
- R3: While `virt_on` is 1, CSR 0x150 reaches the virtual-supervisor select register and CSR 0x151 reaches the virtual-supervisor data window. CSR numbers 0x350/0x351 are machine, 0x150/0x151 supervisor and 0x250/0x251 virtual-supervisor.
- R4: A priority access covers 4 entries when `xlen64` is 0 and 8 entries when it is 1, with entry i of the group at bits 8i+7:8i. The first entry is ((select-0x30)/(XLEN/32))·(entries per access). With `xlen64` 0, bits 63:32 read as zero and are not written.
- R5: With `xlen64` 1, an odd priority select value fails with an illegal-instruction fault.
- R6: Entry 11 of the machine array and entry 9 of the supervisor array always read zero and ignore writes.
- R7: A priority select reached through the virtual-supervisor data window always fails.
- R8: Interrupt-file selects are forwarded (`fwd_valid` 1, with select, level, guest index, data and mask) only if the port is present for that level (`file_here_m` for machine, `file_here_s` otherwise). Otherwise the access fails. `fwd_err` makes a forwarded access fail, and `fwd_rdata` is returned when it succeeds.
- R9: A virtual-supervisor interrupt-file access also needs a `guest_idx` that is nonzero and no larger than `guest_count`. Otherwise it fails and is not forwarded.
- R10: A failure sets `err_virtual` when `virt_on` is 1 and the target is the virtual-supervisor window, and sets `err_illegal` otherwise. An unknown CSR number or a select outside both ranges fails. A failed access reads 0 and changes nothing.
- R11: After reset all select registers and priority entries are zero. With `csr_en` low the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | Access strobe |
| csr_num | input | 12 | CSR number |
| csr_wdata | input | 64 | New value |
| csr_wmask | input | 64 | Write mask |
| xlen64 | input | 1 | 1: XLEN 64, 0: XLEN 32 |
| virt_on | input | 1 | Virtualization active |
| guest_idx | input | 6 | Selected guest interrupt file |
| guest_count | input | 6 | Number of guest interrupt files |
| file_here_m | input | 1 | Machine-level interrupt file port present |
| file_here_s | input | 1 | Supervisor-level interrupt file port present |
| csr_rdata | output | 64 | Old value |
| err_illegal | output | 1 | Illegal-instruction fault |
| err_virtual | output | 1 | Virtual-instruction fault |
| fwd_valid | output | 1 | Forwarded interrupt-file access |
| fwd_sel | output | 12 | Forwarded select value |
| fwd_mlevel | output | 1 | Forward targets machine level |
| fwd_virt | output | 1 | Forward targets a guest file |
| fwd_guest | output | 6 | Guest file index (0 if not virtual) |
| fwd_wdata | output | 64 | Forwarded new value |
| fwd_wmask | output | 64 | Forwarded write mask |
| fwd_rdata | input | 64 | Interrupt-file read data |
| fwd_err | input | 1 | Interrupt-file access error |

## Verification
Read data, the fault flags and every forwarding output are due in the same cycle as the strobe. The bench drives an access at the falling edge and samples these outputs 1 ns later. A state change shows up only on the next access, after the following rising edge. Because of that, every write is confirmed by a later read that goes through a reference model updated in step with the clock. Directed cases cover packing across both XLENs, the hardwired entries, redirection, guest index limits and both fault kinds. These are mixed with seeded random accesses.

// File: rtl/irq_prio_window.sv
module irq_prio_window #(
  parameter logic [11:0] MSEL_NUM = 12'h350,
  parameter logic [11:0] MREG_NUM = 12'h351,
  parameter logic [11:0] SSEL_NUM = 12'h150,
  parameter logic [11:0] SREG_NUM = 12'h151,
  parameter logic [11:0] VSEL_NUM = 12'h250,
  parameter logic [11:0] VREG_NUM = 12'h251,
  parameter int SEL_W = 12,
  parameter logic [SEL_W-1:0] SEL_LEGAL = '1,
  parameter logic [SEL_W-1:0] PRIO_FIRST = 12'h030,
  parameter logic [SEL_W-1:0] FILE_FIRST = 12'h070,
  parameter logic [SEL_W-1:0] FILE_LAST = 12'h0FF,
  parameter int M_EXT_IRQ = 11,
  parameter int S_EXT_IRQ = 9,
  parameter int GUEST_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_en,
  input  logic [11:0]        csr_num,
  input  logic [63:0]        csr_wdata,
  input  logic [63:0]        csr_wmask,
  input  logic               xlen64,
  input  logic               virt_on,
  input  logic [GUEST_W-1:0] guest_idx,
  input  logic [GUEST_W-1:0] guest_count,
  input  logic               file_here_m,
  input  logic               file_here_s,
  output logic [63:0]        csr_rdata,
  output logic               err_illegal,
  output logic               err_virtual,
  output logic               fwd_valid,
  output logic [SEL_W-1:0]   fwd_sel,
  output logic               fwd_mlevel,
  output logic               fwd_virt,
  output logic [GUEST_W-1:0] fwd_guest,
  output logic [63:0]        fwd_wdata,
  output logic [63:0]        fwd_wmask,
  input  logic [63:0]        fwd_rdata,
  input  logic               fwd_err
);
  localparam int ENTRIES = 64;
  localparam logic [SEL_W-1:0] PRIO_LAST = PRIO_FIRST + SEL_W'(15);

  logic [SEL_W-1:0] msel, ssel, vsel;
  logic [7:0] mprio [ENTRIES];
  logic [7:0] sprio [ENTRIES];

  wire m_sel = csr_num == MSEL_NUM;
  wire s_sel = csr_num == SSEL_NUM && !virt_on;
  wire v_sel = csr_num == VSEL_NUM || (csr_num == SSEL_NUM && virt_on);
  wire m_reg = csr_num == MREG_NUM;
  wire s_reg = csr_num == SREG_NUM && !virt_on;
  wire v_reg = csr_num == VREG_NUM || (csr_num == SREG_NUM && virt_on);

  wire sel_acc  = m_sel | s_sel | v_sel;
  wire reg_acc  = m_reg | s_reg | v_reg;
  wire vs_tgt   = v_sel | v_reg;
  wire m_tgt    = m_sel | m_reg;

  wire [SEL_W-1:0] cur_sel = m_tgt ? msel : (vs_tgt ? vsel : ssel);
  wire [63:0] dmask = xlen64 ? '1 : {32'h0, 32'hFFFF_FFFF};
  wire [63:0] wm = csr_wmask & dmask;
  wire [63:0] wd = csr_wdata & dmask;

  wire in_prio = cur_sel >= PRIO_FIRST && cur_sel <= PRIO_LAST;
  wire in_file = cur_sel >= FILE_FIRST && cur_sel <= FILE_LAST;
  wire [3:0] grp = cur_sel[3:0] - PRIO_FIRST[3:0];
  wire [5:0] base = {grp, 2'b00};
  wire [3:0] nlanes = xlen64 ? 4'd8 : 4'd4;

  logic [63:0] old_prio;
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      logic [5:0] idx;
      idx = base + 6'(i);
      old_prio[8*i +: 8] = (i < 4 || xlen64) ? (m_tgt ? mprio[idx] : sprio[idx]) : 8'h00;
    end
  end

  wire [63:0] new_prio = (old_prio & ~wm) | (wd & wm);
  logic [7:0] newb [8];
  always_comb
    for (int i = 0; i < 8; i++) newb[i] = new_prio[8*i +: 8];

  wire file_here = m_tgt ? file_here_m : file_here_s;
  wire guest_ok  = !vs_tgt || (guest_idx != '0 && guest_idx <= guest_count);

  wire reg_fail = in_prio ? (vs_tgt || (xlen64 && cur_sel[0]))
                : in_file ? (!file_here || !guest_ok || fwd_err)
                : 1'b1;
  wire fail = csr_en && (!(sel_acc | reg_acc) || (reg_acc && reg_fail));

  assign err_virtual = fail && virt_on && vs_tgt;
  assign err_illegal = fail && !err_virtual;

  assign fwd_valid  = csr_en && reg_acc && in_file && file_here && guest_ok;
  assign fwd_sel    = cur_sel;
  assign fwd_mlevel = m_tgt;
  assign fwd_virt   = vs_tgt;
  assign fwd_guest  = vs_tgt ? guest_idx : '0;
  assign fwd_wdata  = wd;
  assign fwd_wmask  = wm;

  always_comb begin
    if (!csr_en || fail)  csr_rdata = '0;
    else if (sel_acc)     csr_rdata = 64'(cur_sel);
    else if (in_prio)     csr_rdata = old_prio;
    else                  csr_rdata = fwd_rdata & dmask;
  end

  wire [SEL_W-1:0] smask   = wm[SEL_W-1:0] & SEL_LEGAL;
  wire [SEL_W-1:0] sel_new = (cur_sel & ~smask) | (wd[SEL_W-1:0] & smask);
  wire sel_we  = csr_en && sel_acc && smask != '0;
  wire prio_we = csr_en && reg_acc && in_prio && !reg_fail && wm != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel <= '0;
      ssel <= '0;
      vsel <= '0;
    end else if (sel_we) begin
      if (m_sel) msel <= sel_new;
      if (s_sel) ssel <= sel_new;
      if (v_sel) vsel <= sel_new;
    end
  end

  for (genvar j = 0; j < ENTRIES; j++) begin : g_entry
    wire [5:0] off = 6'(j) - base;
    wire hit = prio_we && off < 6'(nlanes);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mprio[j] <= '0;
        sprio[j] <= '0;
      end else if (hit) begin
        if (m_tgt && j != M_EXT_IRQ) mprio[j] <= newb[off[2:0]];
        if (!m_tgt && j != S_EXT_IRQ) sprio[j] <= newb[off[2:0]];
      end
    end
  end
endmodule

module irq_prio_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_en,
  input logic        virt_on,
  input logic [5:0]  guest_idx,
  input logic [5:0]  guest_count,
  input logic [63:0] csr_rdata,
  input logic        err_illegal,
  input logic        err_virtual,
  input logic        fwd_valid,
  input logic [11:0] fwd_sel,
  input logic        fwd_virt,
  input logic [5:0]  fwd_guest
);
  // R10
  one_fault_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_illegal, err_virtual}));
  // R10
  virt_fault_needs_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_virtual |-> virt_on);
  // R9
  guest_index_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_virt) |-> (fwd_guest != 6'd0 && fwd_guest <= guest_count && fwd_guest == guest_idx));
  // R8
  fwd_in_file_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (csr_en && fwd_sel >= 12'h070 && fwd_sel <= 12'h0FF));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en |-> (csr_rdata == 64'd0 && !err_illegal && !err_virtual && !fwd_valid));
endmodule

bind irq_prio_window irq_prio_window_chk chk (.*);

// File: tb/tb_irq_prio_window.sv
module tb_irq_prio_window;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic csr_en = 0, xlen64 = 0, virt_on = 0, file_here_m = 0, file_here_s = 0, fwd_err = 0;
  logic [11:0] csr_num = 0;
  logic [63:0] csr_wdata = 0, csr_wmask = 0, fwd_rdata = 0;
  logic [5:0] guest_idx = 0, guest_count = 0;
  logic [63:0] csr_rdata, fwd_wdata, fwd_wmask;
  logic err_illegal, err_virtual, fwd_valid, fwd_mlevel, fwd_virt;
  logic [11:0] fwd_sel;
  logic [5:0] fwd_guest;

  irq_prio_window dut (.*);

  int checks = 0, errors = 0;
  logic [7:0] bm [64];
  logic [7:0] bs [64];
  logic [11:0] bsel [3];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic acc(string tag, logic [11:0] num, logic [63:0] wdv, logic [63:0] wmv,
                     bit x64, bit vi, logic [5:0] gi, logic [5:0] gc,
                     bit hm, bit hs, bit ferr, logic [63:0] frd);
    logic [63:0] dm, m, d, erd, old, nv;
    int kind, lvl, n, first;
    bit fail, fv, ev;
    logic [11:0] s;
    @(negedge clk);
    csr_en = 1; csr_num = num; csr_wdata = wdv; csr_wmask = wmv; xlen64 = x64;
    virt_on = vi; guest_idx = gi; guest_count = gc; file_here_m = hm; file_here_s = hs;
    fwd_err = ferr; fwd_rdata = frd;
    #1;
    dm = x64 ? '1 : 64'hFFFF_FFFF;
    m = wmv & dm; d = wdv & dm;
    kind = 0; lvl = 0;
    case (num)
      12'h350: begin kind = 1; lvl = 0; end
      12'h150: begin kind = 1; lvl = vi ? 2 : 1; end
      12'h250: begin kind = 1; lvl = 2; end
      12'h351: begin kind = 2; lvl = 0; end
      12'h151: begin kind = 2; lvl = vi ? 2 : 1; end
      12'h251: begin kind = 2; lvl = 2; end
      default: kind = 0;
    endcase
    s = bsel[lvl];
    fail = 0; fv = 0; erd = 0; old = 0; first = 0; n = 0;
    if (kind == 0) fail = 1;
    else if (kind == 1) erd = 64'(s);
    else if (s >= 12'h030 && s <= 12'h03F) begin
      if (lvl == 2 || (x64 && s[0])) fail = 1;
      else begin
        n = x64 ? 8 : 4;
        first = ((int'(s) - 'h30) / (x64 ? 2 : 1)) * n;
        for (int i = 0; i < n; i++) old[8*i +: 8] = (lvl == 0) ? bm[first+i] : bs[first+i];
        erd = old;
      end
    end else if (s >= 12'h070 && s <= 12'h0FF) begin
      if (!((lvl == 0) ? hm : hs)) fail = 1;
      else if (lvl == 2 && (gi == 0 || gi > gc)) fail = 1;
      else begin
        fv = 1;
        if (ferr) fail = 1; else erd = frd & dm;
      end
    end else fail = 1;
    if (fail) erd = 0;
    ev = fail && vi && lvl == 2;
    chk(tag, "rdata", csr_rdata, erd);
    chk(tag, "err_illegal", 64'(err_illegal), 64'(fail && !ev));
    chk(tag, "err_virtual", 64'(err_virtual), 64'(ev));
    chk(tag, "fwd_valid", 64'(fwd_valid), 64'(fv));
    if (fv) begin
      chk(tag, "fwd_sel", 64'(fwd_sel), 64'(s));
      chk(tag, "fwd_mlevel", 64'(fwd_mlevel), 64'(lvl == 0));
      chk(tag, "fwd_guest", 64'(fwd_guest), (lvl == 2) ? 64'(gi) : 64'd0);
      chk(tag, "fwd_wmask", fwd_wmask, m);
      chk(tag, "fwd_wdata", fwd_wdata, d);
    end
    if (!fail && kind == 1) bsel[lvl] = (s & ~m[11:0]) | (d[11:0] & m[11:0]);
    if (!fail && kind == 2 && n != 0) begin
      nv = (old & ~m) | (d & m);
      for (int i = 0; i < n; i++) begin
        if (lvl == 0 && first + i != 11) bm[first+i] = nv[8*i +: 8];
        if (lvl == 1 && first + i != 9)  bs[first+i] = nv[8*i +: 8];
      end
    end
    @(posedge clk);
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] ONES = '1;

  initial begin
    logic [11:0] nums [7];
    nums = '{12'h350, 12'h351, 12'h150, 12'h151, 12'h250, 12'h251, 12'h123};
    for (int i = 0; i < 64; i++) begin bm[i] = 0; bs[i] = 0; end
    for (int i = 0; i < 3; i++) bsel[i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R11 idle outputs after reset
    chk("R11", "idle rdata", csr_rdata, 0);
    chk("R11", "idle err", 64'({err_illegal, err_virtual, fwd_valid}), 0);
    rst_n = 1;
    acc("R11", 12'h350, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R11", 12'h351, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R2 legal bits
    acc("R2", 12'h350, 64'hFFFF_FFFF_FFFF_F123, ONES, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R2", 12'h350, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R1 zero and partial masks
    acc("R1", 12'h350, 64'h031, 64'h0F0, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R1", 12'h350, 64'h0, 64'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R1", 12'h350, 64'h031, ONES, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4 XLEN 32 group write then XLEN 64 read
    acc("R4", 12'h351, 64'hDEAD_BEEF_0403_0201, ONES, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R1", 12'h351, 64'hFF, 64'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R4", 12'h350, 64'h030, ONES, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R4", 12'h351, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R6 hardwired external entries
    acc("R6", 12'h350, 64'h032, ONES, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R6", 12'h351, ONES, ONES, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R6", 12'h351, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R6", 12'h150, 64'h032, ONES, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R6", 12'h151, ONES, ONES, 0, 0, 0, 0, 0, 0, 0, 0);
    acc("R6", 12'h151, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 odd select at XLEN 64
    acc("R5", 12'h350, 64'h033, ONES, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R5", 12'h351, ONES, ONES, 1, 0, 0, 0, 0, 0, 0, 0);
    // R3 redirection
    acc("R3", 12'h150, 64'h030, ONES, 1, 1, 0, 0, 0, 0, 0, 0);
    acc("R3", 12'h250, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R3", 12'h150, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R7 priority through virtual window
    acc("R7", 12'h151, ONES, ONES, 1, 1, 1, 1, 1, 1, 0, 0);
    acc("R7", 12'h251, ONES, ONES, 1, 0, 1, 1, 1, 1, 0, 0);
    // R8 forwarding presence and error
    acc("R8", 12'h350, 64'h070, ONES, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R8", 12'h351, 1, ONES, 1, 0, 0, 0, 0, 1, 0, 64'h1234);
    acc("R8", 12'h351, 1, ONES, 1, 0, 0, 0, 1, 0, 1, 64'h1234);
    acc("R8", 12'h351, 1, ONES, 0, 0, 0, 0, 1, 0, 0, 64'hAAAA_5555_1234_5678);
    // R9 guest index limits
    acc("R9", 12'h250, 64'h080, ONES, 1, 1, 0, 0, 0, 0, 0, 0);
    acc("R9", 12'h151, 0, ONES, 1, 1, 0, 2, 1, 1, 0, 64'h77);
    acc("R9", 12'h151, 0, ONES, 1, 1, 3, 2, 1, 1, 0, 64'h77);
    acc("R9", 12'h151, 0, ONES, 1, 1, 2, 2, 1, 1, 0, 64'h77);
    // R10 unknown number and unmapped select
    acc("R10", 12'h123, 0, ONES, 1, 0, 0, 0, 1, 1, 0, 0);
    acc("R10", 12'h350, 64'h040, ONES, 1, 0, 0, 0, 0, 0, 0, 0);
    acc("R10", 12'h351, ONES, ONES, 1, 0, 0, 0, 1, 1, 0, 0);
    acc("R10", 12'h251, ONES, ONES, 1, 1, 0, 0, 1, 1, 1, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic [11:0] num;
      logic [63:0] wdv, wmv;
      string tag;
      r = $urandom;
      num = nums[$urandom % 7];
      case (r % 4)
        0: wdv = 64'(12'h030 + 12'((r >> 4) % 16));
        1: wdv = 64'(12'h070 + 12'((r >> 8) % 144));
        2: wdv = {$urandom, $urandom};
        default: wdv = 64'h040;
      endcase
      case ((r >> 20) % 4)
        0: wmv = 0;
        1: wmv = {$urandom, $urandom};
        default: wmv = ONES;
      endcase
      if (num[0] == 1'b0 && num != 12'h123) tag = "R2";
      else if (num == 12'h123) tag = "R10";
      else tag = "R4";
      acc(tag, num, wdv, wmv, ($urandom % 2) == 1, ($urandom % 3) == 0,
          6'($urandom % 8), 6'($urandom % 8), ($urandom % 4) != 0,
          ($urandom % 4) != 0, ($urandom % 8) == 0, {$urandom, $urandom});
    end
    @(negedge clk);
    csr_en = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule